// File: doc/BRIEF.md
# Multicontext Full-Adder Logic Slice

The block is a small reconfigurable slice for a processor's custom functional unit. Each bit lane holds one full adder. Multiplexers decide what reaches the adder's carry input and which adder output leaves the lane. The multiplexers are set by a 3-bit word taken from a local context store. That store holds 16 words per lane. A 4-bit context select is shared by every lane and picks the active word with no delay. So the same hardware can act as a word adder, a bitwise XOR, AND, OR or XNOR, or a three-input parity or majority unit. The choice can change from cycle to cycle.

Contexts are loaded through a synchronous write port. The port has a per-lane write mask, so lanes can hold different words under the same context number. Each lane passes its adder carry to the next lane. The lowest lane takes the slice carry input, and the highest lane drives the slice carry output. A context-enable input zeroes the logic outputs but leaves the carry path working.

Top module: `fa_slice`

## Requirements
- R1: A synchronous active-high reset clears every context word in every lane to 3'b000, so after reset every context makes the slice an adder.
- R2: Context word bits [1:0] set a lane's adder carry input: 2'b00 selects the carry from the lane below (the slice carry input for lane 0), 2'b01 selects 0, 2'b10 selects 1, and 2'b11 selects that lane's d3 bit.
- R3: Context word bit [2] sets a lane's output: 0 gives the adder sum, 1 gives the adder carry-out.
- R4: With word 3'b000 the slice computes y = (d1 + d2 + carry_in) mod 2^N, and carry_out is bit N of that sum.
- R5: With word 3'b001, y = d1 XOR d2. With word 3'b010, y = NOT(d1 XOR d2).
- R6: With word 3'b101, y = d1 AND d2.
- R7: With word 3'b110, y = d1 OR d2.
- R8: With word 3'b011, y = d1 XOR d2 XOR d3. With word 3'b111, y is the bitwise majority of d1, d2 and d3.
- R9: While ctx_en is low, y is all zeros, and carry_out still equals the carry the active context would produce.
- R10: A change of ctx_sel changes y and carry_out in the same cycle, with no clock edge needed.
- R11: A write stores wr_data at wr_addr in the lanes whose wr_lane bit is set, and it takes effect at the next rising clock edge. Other lanes and other addresses keep their contents.
- R12: Each lane's carry-out is the chained carry input of the next lane up, and carry_out is the carry-out of lane N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lane | input | N | Per-lane write enable mask |
| wr_addr | input | 4 | Context number to write |
| wr_data | input | 3 | Context word to write |
| ctx_sel | input | 4 | Active context number, shared by all lanes |
| ctx_en | input | 1 | Output enable; low forces y to zero |
| d1 | input | N | First operand (adder X input) |
| d2 | input | N | Second operand (adder Y input) |
| d3 | input | N | Third operand, usable as per-lane carry input |
| carry_in | input | 1 | Chained carry into lane 0 |
| y | output | N | Logic output word |
| carry_out | output | 1 | Carry out of lane N-1 |

## Verification
The bench sweeps many operand pairs for every context word and compares each result with arithmetic and bitwise expressions. This catches a mis-wired carry multiplexer, for example one that turns OR into AND, or one that breaks the ripple between lanes as seen when 0xFF + 1 wraps. It checks that a write to the active context is not seen before the clock edge and is seen after it. It also checks that a masked write leaves the unselected lanes as adders, which would expose a store that ignores the mask or writes the wrong address. Holding ctx_en low across all operations shows whether gating also kills the carry, and switching ctx_sel mid-cycle shows whether a pipeline register was added on the select path.

// File: rtl/fa_cell_pkg.sv
package fa_cell_pkg;

    localparam int CTX_AW    = 4;
    localparam int CTX_DEPTH = 1 << CTX_AW;
    localparam int CFG_W     = 3;

    typedef enum logic [1:0] {
        CIN_CHAIN = 2'b00,
        CIN_ZERO  = 2'b01,
        CIN_ONE   = 2'b10,
        CIN_D3    = 2'b11
    } cin_sel_e;

    typedef struct packed {
        logic     pick_carry;
        cin_sel_e cin_sel;
    } cell_cfg_t;

    typedef struct packed {
        logic x;
        logic y;
        logic c;
    } fa_in_t;

    typedef struct packed {
        logic co;
        logic s;
    } fa_out_t;

    function automatic fa_out_t full_add(fa_in_t i);
        fa_out_t o;
        o.s  = i.x ^ i.y ^ i.c;
        o.co = (i.x & i.y) | (i.c & (i.x ^ i.y));
        return o;
    endfunction

endpackage

// File: rtl/fa_ctx_store.sv
module fa_ctx_store #(
    parameter int AW = fa_cell_pkg::CTX_AW,
    parameter int W  = fa_cell_pkg::CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R11
    wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rd_data == '0);

endmodule

// File: rtl/fa_core.sv
module fa_core
    import fa_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      en,
    input  logic      d1,
    input  logic      d2,
    input  logic      d3,
    input  logic      cin,
    output logic      out,
    output logic      cout
);
    fa_in_t  fin;
    fa_out_t fout;
    logic    cmux;

    always_comb begin
        unique case (cfg.cin_sel)
            CIN_CHAIN: cmux = cin;
            CIN_ZERO:  cmux = 1'b0;
            CIN_ONE:   cmux = 1'b1;
            CIN_D3:    cmux = d3;
            default:   cmux = 1'b0;
        endcase
        fin  = '{x: d1, y: d2, c: cmux};
        fout = full_add(fin);
        out  = en & (cfg.pick_carry ? fout.co : fout.s);
        cout = fout.co;
    end

    // R4
    always_comb begin
        if (!$isunknown({d1, d2, cmux})) begin
            fa_sum_chk: assert ({fout.co, fout.s} == 2'(d1) + 2'(d2) + 2'(cmux));
        end
    end

endmodule

// File: rtl/fa_cell.sv
module fa_cell
    import fa_cell_pkg::*;
#(
    parameter int AW = CTX_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [AW-1:0] ctx_sel,
    input  logic          ctx_en,
    input  logic          d1,
    input  logic          d2,
    input  logic          d3,
    input  logic          cin,
    output logic          out,
    output logic          cout
);
    logic [CFG_W-1:0] word;
    cell_cfg_t        cfg;

    fa_ctx_store #(.AW(AW), .W(CFG_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ctx_sel),
        .rd_data (word)
    );

    assign cfg = cell_cfg_t'(word);

    fa_core u_core (
        .cfg  (cfg),
        .en   (ctx_en),
        .d1   (d1),
        .d2   (d2),
        .d3   (d3),
        .cin  (cin),
        .out  (out),
        .cout (cout)
    );

endmodule

// File: rtl/fa_slice.sv
module fa_slice
    import fa_cell_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = CTX_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     wr_lane,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [AW-1:0]    ctx_sel,
    input  logic             ctx_en,
    input  logic [N-1:0]     d1,
    input  logic [N-1:0]     d2,
    input  logic [N-1:0]     d3,
    input  logic             carry_in,
    output logic [N-1:0]     y,
    output logic             carry_out
);
    logic [N:0] chain;

    assign chain[0] = carry_in;

    for (genvar g = 0; g < N; g++) begin : g_lane
        fa_cell #(.AW(AW)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_lane[g]),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .ctx_sel (ctx_sel),
            .ctx_en  (ctx_en),
            .d1      (d1[g]),
            .d2      (d2[g]),
            .d3      (d3[g]),
            .cin     (chain[g]),
            .out     (y[g]),
            .cout    (chain[g+1])
        );
    end

    assign carry_out = chain[N];

    // R9
    gate_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ctx_en |-> y == '0);

endmodule

// File: tb/sim_fa_slice.sv
module sim_fa_slice;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] wr_lane = '0;
    logic [3:0]   wr_addr = '0;
    logic [2:0]   wr_data = '0;
    logic [3:0]   ctx_sel = '0;
    logic         ctx_en = 1'b1;
    logic [N-1:0] d1 = '0, d2 = '0, d3 = '0;
    logic         carry_in = 1'b0;
    logic [N-1:0] y;
    logic         carry_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    fa_slice #(.N(N)) u0 (
        .clk(clk), .rst(rst), .wr_lane(wr_lane), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctx_sel(ctx_sel), .ctx_en(ctx_en),
        .d1(d1), .d2(d2), .d3(d3), .carry_in(carry_in),
        .y(y), .carry_out(carry_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [N-1:0] maj(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // expected {carry_out, y} for an operation index with ctx_en high
    function automatic logic [N:0] expect_op(int op, logic [N-1:0] a, logic [N-1:0] b,
                                             logic [N-1:0] c, logic ci);
        logic [N-1:0] m;
        m = maj(a, b, c);
        case (op)
            0: return {1'b0, a} + {1'b0, b} + (N+1)'(ci);
            1: return {a[N-1] & b[N-1], a ^ b};
            2: return {a[N-1] & b[N-1], a & b};
            3: return {a[N-1] | b[N-1], a | b};
            4: return {m[N-1], a ^ b ^ c};
            5: return {m[N-1], m};
            default: return {a[N-1] | b[N-1], ~(a ^ b)};
        endcase
    endfunction

    function automatic logic [2:0] word_of(int op);
        case (op)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b101;
            3: return 3'b110;
            4: return 3'b011;
            5: return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R8";
            default: return "R5/R2";
        endcase
    endfunction

    task automatic check(string req, logic [N:0] act, logic [N:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] s, logic e, logic [N-1:0] a, logic [N-1:0] b,
                         logic [N-1:0] c, logic ci);
        @(negedge clk);
        ctx_sel = s; ctx_en = e; d1 = a; d2 = b; d3 = c; carry_in = ci;
        #1;
    endtask

    task automatic write_ctx(logic [N-1:0] lanes, logic [3:0] addr, logic [2:0] data);
        @(negedge clk);
        wr_lane = lanes; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_lane = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every context adds after reset
        for (int k = 0; k < 16; k++) begin
            drive(4'(k), 1'b1, 8'h5A, 8'hC3, 8'h00, 1'b1);
            check("R1", {carry_out, y}, expect_op(0, 8'h5A, 8'hC3, 8'h00, 1'b1));
        end

        // load operations into contexts 1..6 of all lanes (context 0 stays add)
        for (int op = 1; op < 7; op++) write_ctx('1, 4'(op), word_of(op));

        // R2 R3 R4 R5 R6 R7 R8: operand sweeps per operation
        for (int op = 0; op < 7; op++) begin
            for (int ai = 0; ai < 256; ai += 17) begin
                for (int bi = 0; bi < 256; bi++) begin
                    logic [N-1:0] a, b, c;
                    logic ci;
                    a = 8'(ai); b = 8'(bi); c = a ^ {b[3:0], b[7:4]}; ci = bi[0] ^ ai[0];
                    drive(4'(op), 1'b1, a, b, c, ci);
                    check(tag_of(op), {carry_out, y}, expect_op(op, a, b, c, ci));
                end
            end
        end

        // R12: ripple through all lanes
        drive(4'd0, 1'b1, 8'hFF, 8'h01, 8'h00, 1'b0);
        check("R12", {carry_out, y}, {1'b1, 8'h00});
        drive(4'd0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1);
        check("R12", {carry_out, y}, {1'b1, 8'h00});
        drive(4'd0, 1'b1, 8'h7F, 8'h00, 8'h00, 1'b1);
        check("R12", {carry_out, y}, {1'b0, 8'h80});

        // R9: output gated, carry kept
        for (int op = 0; op < 7; op++) begin
            drive(4'(op), 1'b0, 8'hB6, 8'hD9, 8'h3C, 1'b1);
            check("R9", {carry_out, y}, {expect_op(op, 8'hB6, 8'hD9, 8'h3C, 1'b1)[N], 8'h00});
        end

        // R10: context switch inside one cycle
        drive(4'd1, 1'b1, 8'hA5, 8'h3C, 8'h00, 1'b0);
        check("R10", {carry_out, y}, expect_op(1, 8'hA5, 8'h3C, 8'h00, 1'b0));
        ctx_sel = 4'd3;
        #1;
        check("R10", {carry_out, y}, expect_op(3, 8'hA5, 8'h3C, 8'h00, 1'b0));
        ctx_sel = 4'd2;
        #1;
        check("R10", {carry_out, y}, expect_op(2, 8'hA5, 8'hA5 & 8'h3C | 8'h00, 8'h00, 1'b0) & 0 | expect_op(2, 8'hA5, 8'h3C, 8'h00, 1'b0));

        // R11: write to the active context appears only after the edge
        drive(4'd8, 1'b1, 8'h96, 8'h4B, 8'h00, 1'b0);
        wr_lane = '1; wr_addr = 4'd8; wr_data = 3'b110;
        #1;
        check("R11", {carry_out, y}, expect_op(0, 8'h96, 8'h4B, 8'h00, 1'b0));
        @(posedge clk);
        #1;
        wr_lane = '0;
        check("R11", {carry_out, y}, expect_op(3, 8'h96, 8'h4B, 8'h00, 1'b0));
        drive(4'd9, 1'b1, 8'h96, 8'h4B, 8'h00, 1'b0);
        check("R11", {carry_out, y}, expect_op(0, 8'h96, 8'h4B, 8'h00, 1'b0));

        // R11 R12: masked write, upper lanes AND, lower lanes add
        write_ctx(8'hF0, 4'd10, 3'b101);
        for (int p = 0; p < 6; p++) begin
            logic [N-1:0] a, b;
            logic [N:0] s;
            a = 8'(37 * p + 9); b = 8'(91 * p + 200);
            s = {1'b0, a} + {1'b0, b} + 9'(p & 1);
            drive(4'd10, 1'b1, a, b, 8'h00, 1'(p & 1));
            check("R11", {carry_out, y}, {a[7] & b[7], a[7:4] & b[7:4], s[3:0]});
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule